// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block runs the command and address phase of a page read on an asynchronous NAND device with an 8-bit or 16-bit bus. A request carries a block number, a page number, a column offset and a flag asking for the spare area instead of the data area. The sequencer latches the request and waits for the device's ready/busy line to show ready. It then strobes out the read opcode, the column and row address bytes and the confirm opcode. Last, it waits for ready again and raises a one-cycle pulse that tells the data-transfer logic it may start reading.

Requests enter through a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request is taken on the clock edge where `req_valid` and `req_ready` are both high. A held `req_valid` during a running sequence is simply not taken until the sequencer returns to idle. Configuration pins for bus width, the optional fifth address cycle and the strobe setup and hold counts are sampled at acceptance. A ready timeout aborts a stuck sequence and raises an error flag. A small comparator classifies a bad-block marker word.

Top module: `nand_read_seq`

## Requirements
- R1: During and right after reset, `nand_ce_n` and `nand_we_n` are 1, `nand_cle`, `nand_ale`, `busy`, `done` and `timeout_err` are 0, and `req_ready` is 1.
- R2: After a request is accepted, no write strobe occurs until `nand_rb` reads 1 (ready); chip enable is already low while waiting.
- R3: The bytes strobed on `nand_io[7:0]` are, in order: opcode 0x00 with CLE, column low, column high, row low, row middle, an optional row high (all with ALE), and opcode 0x30 with CLE. CLE and ALE are never high together, and every strobe has exactly one of them high.
- R4: The row address equals `req_page + req_block * PAGES_PER_BLOCK`.
- R5: When `req_oob` is 1, PAGE_BYTES is added to the column offset before it is sent.
- R6: When `cfg_bus16` is 1, the column value, after any spare-area addition, is shifted right by one bit.
- R7: When `cfg_five_cycle` is 1, a fifth address byte is sent after row middle, holding row bits [19:16] in its low nibble and zeros in its high nibble; otherwise it is skipped.
- R8: For each byte, `nand_we_n` is low for `cfg_setup+1` cycles and then high for `cfg_hold+1` cycles, with `nand_io` and the latch signals held through both phases.
- R9: Between the last address byte and the confirm opcode there is exactly one extra cycle with CLE, ALE and the strobe all inactive.
- R10: `busy` is high from the cycle after acceptance until the sequence ends, `req_ready` is its inverse, and `done` pulses for one cycle, the cycle after the post-confirm ready is sampled, with `busy` already low.
- R11: If `nand_rb` stays 0 for READY_TIMEOUT cycles in either wait, the sequence ends without `done`, `timeout_err` goes to 1 with `nand_ce_n` high, and the flag holds until the next accepted request clears it.
- R12: `mark_bad` is 0 only when the marker reads all ones: `mark_word[7:0]` equal to 0xFF on an 8-bit bus (upper byte ignored), or all 16 bits equal to 0xFFFF when `cfg_bus16` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_block | input | BLOCK_W | Block number |
| req_page | input | PAGE_W | Page within block |
| req_col | input | COL_W | Column byte offset |
| req_oob | input | 1 | Read the spare area |
| cfg_bus16 | input | 1 | Device has a 16-bit bus |
| cfg_five_cycle | input | 1 | Send a fifth address byte |
| cfg_setup | input | TIM_W | Strobe low length minus one |
| cfg_hold | input | TIM_W | Strobe high length minus one |
| nand_rb | input | 1 | Device ready (1) or busy (0) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 16 | IO bus, bytes on bits 7:0 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse, data may be read |
| timeout_err | output | 1 | Ready wait expired |
| mark_word | input | 16 | Bad-block marker as read |
| mark_bad | output | 1 | Marker is not all ones |

## Verification
`busy` rises one cycle after the accepting edge, and `done` rises one cycle after the edge that first samples ready following the confirm byte. The strobe's low phase lasts `cfg_setup+1` cycles, and the high phase between address bytes lasts `cfg_hold+1`; before the confirm byte it is one cycle longer. The bench drives inputs and samples every output at the falling clock edge. It counts cycles there and records each strobe edge with the byte and latch signals, so each width and latency is checked as an exact count of those falling edges. Its device model drops ready at the confirm strobe and records the cycle it releases ready, and the cycle of `done` is checked against that cycle plus one.

// File: rtl/nrs_pkg.sv
`timescale 1ns/1ps
package nrs_pkg;
  localparam int ROW_W = 20;
  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_CONFIRM = 8'h30;

  localparam logic [2:0] SLOT_CMD     = 3'd0;
  localparam logic [2:0] SLOT_ROW_MID = 3'd4;
  localparam logic [2:0] SLOT_ROW_HI  = 3'd5;
  localparam logic [2:0] SLOT_CONFIRM = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_PRE,
    ST_SETUP,
    ST_HOLD,
    ST_GAP,
    ST_WAIT_POST
  } seq_state_t;
endpackage

// File: rtl/nrs_addr_gen.sv
`timescale 1ns/1ps
module nrs_addr_gen import nrs_pkg::*; #(
  parameter int BLOCK_W         = 14,
  parameter int PAGE_W          = 6,
  parameter int COL_W           = 12,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_BYTES      = 2048
) (
  input  logic [BLOCK_W-1:0] block,
  input  logic [PAGE_W-1:0]  page,
  input  logic [COL_W-1:0]   col,
  input  logic               oob,
  input  logic               bus16,
  input  logic [2:0]         slot,
  output logic [7:0]         byte_val,
  output logic               is_cmd
);
  localparam int CE_W = COL_W + 1;

  logic [ROW_W-1:0] row;
  logic [CE_W-1:0]  col_sum;
  logic [CE_W-1:0]  col_eff;
  logic [15:0]      col16;

  // Flat row index: pages are numbered across blocks.
  assign row = ROW_W'(block) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(page);

  // Spare-area reads continue past the end of the data area.
  assign col_sum = CE_W'(col) + (oob ? CE_W'(PAGE_BYTES) : CE_W'(0));
  // Wide devices are addressed in words.
  assign col_eff = bus16 ? (col_sum >> 1) : col_sum;

  always_comb begin
    col16 = '0;
    col16[CE_W-1:0] = col_eff;
  end

  always_comb begin
    is_cmd   = 1'b0;
    byte_val = 8'h00;
    unique case (slot)
      3'd0: begin byte_val = OP_READ;    is_cmd = 1'b1; end
      3'd1: byte_val = col16[7:0];
      3'd2: byte_val = col16[15:8];
      3'd3: byte_val = row[7:0];
      3'd4: byte_val = row[15:8];
      3'd5: byte_val = {4'h0, row[19:16]};
      3'd6: begin byte_val = OP_CONFIRM; is_cmd = 1'b1; end
      default: byte_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/nrs_phase_timer.sv
`timescale 1ns/1ps
module nrs_phase_timer #(
  parameter int TIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TIM_W-1:0] load_val,
  output logic             zero
);
  logic [TIM_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - TIM_W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nrs_ready_watch.sv
`timescale 1ns/1ps
module nrs_ready_watch #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rb,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = active && !rb && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!active)           cnt <= '0;
    else if (!rb && !expired)   cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/nand_read_seq.sv
`timescale 1ns/1ps
module nand_read_seq import nrs_pkg::*; #(
  parameter int BLOCK_W         = 14,
  parameter int PAGE_W          = 6,
  parameter int COL_W           = 12,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_BYTES      = 2048,
  parameter int TIM_W           = 4,
  parameter int READY_TIMEOUT   = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BLOCK_W-1:0] req_block,
  input  logic [PAGE_W-1:0]  req_page,
  input  logic [COL_W-1:0]   req_col,
  input  logic               req_oob,
  input  logic               cfg_bus16,
  input  logic               cfg_five_cycle,
  input  logic [TIM_W-1:0]   cfg_setup,
  input  logic [TIM_W-1:0]   cfg_hold,
  input  logic               nand_rb,
  output logic               nand_ce_n,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic [15:0]        nand_io,
  output logic               busy,
  output logic               done,
  output logic               timeout_err,
  input  logic [15:0]        mark_word,
  output logic               mark_bad
);
  seq_state_t state, state_n;
  logic [2:0] slot, slot_n;

  logic [BLOCK_W-1:0] lat_block;
  logic [PAGE_W-1:0]  lat_page;
  logic [COL_W-1:0]   lat_col;
  logic               lat_oob, lat_bus16, lat_five;
  logic [TIM_W-1:0]   lat_setup, lat_hold;

  logic             accept;
  logic             tim_zero, tim_load;
  logic [TIM_W-1:0] tim_val;
  logic             waiting, tmo;
  logic [7:0]       cur_byte;
  logic             cur_cmd;
  logic             in_byte;
  logic             last_addr;

  assign accept = req_valid && (state == ST_IDLE);

  nrs_addr_gen #(
    .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .COL_W(COL_W),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .PAGE_BYTES(PAGE_BYTES)
  ) u_addr (
    .block(lat_block), .page(lat_page), .col(lat_col),
    .oob(lat_oob), .bus16(lat_bus16), .slot(slot),
    .byte_val(cur_byte), .is_cmd(cur_cmd)
  );

  nrs_phase_timer #(.TIM_W(TIM_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tim_load), .load_val(tim_val), .zero(tim_zero)
  );

  assign waiting = (state == ST_WAIT_PRE) || (state == ST_WAIT_POST);

  nrs_ready_watch #(.LIMIT(READY_TIMEOUT)) u_watch (
    .clk(clk), .rst_n(rst_n), .active(waiting), .rb(nand_rb), .expired(tmo)
  );

  // Last address byte depends on whether the fifth cycle is enabled.
  assign last_addr = (slot == SLOT_ROW_HI) || ((slot == SLOT_ROW_MID) && !lat_five);

  always_comb begin
    state_n = state;
    slot_n  = slot;
    unique case (state)
      ST_IDLE:     if (req_valid) state_n = ST_WAIT_PRE;
      ST_WAIT_PRE: begin
        if (tmo) state_n = ST_IDLE;
        else if (nand_rb) begin
          state_n = ST_SETUP;
          slot_n  = SLOT_CMD;
        end
      end
      ST_SETUP:    if (tim_zero) state_n = ST_HOLD;
      ST_HOLD: begin
        if (tim_zero) begin
          if (slot == SLOT_CONFIRM) state_n = ST_WAIT_POST;
          else if (last_addr)       state_n = ST_GAP;
          else begin
            state_n = ST_SETUP;
            slot_n  = slot + 3'd1;
          end
        end
      end
      ST_GAP: begin
        state_n = ST_SETUP;
        slot_n  = SLOT_CONFIRM;
      end
      ST_WAIT_POST: if (tmo || nand_rb) state_n = ST_IDLE;
      default:      state_n = ST_IDLE;
    endcase
  end

  // Phase counter is reloaded on every entry into a strobe phase.
  assign tim_load = (state_n != state) && ((state_n == ST_SETUP) || (state_n == ST_HOLD));
  assign tim_val  = (state_n == ST_SETUP) ? lat_setup : lat_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      slot        <= SLOT_CMD;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      lat_block   <= '0;
      lat_page    <= '0;
      lat_col     <= '0;
      lat_oob     <= 1'b0;
      lat_bus16   <= 1'b0;
      lat_five    <= 1'b0;
      lat_setup   <= '0;
      lat_hold    <= '0;
    end else begin
      state <= state_n;
      slot  <= slot_n;
      done  <= (state == ST_WAIT_POST) && nand_rb;
      if (accept) begin
        lat_block   <= req_block;
        lat_page    <= req_page;
        lat_col     <= req_col;
        lat_oob     <= req_oob;
        lat_bus16   <= cfg_bus16;
        lat_five    <= cfg_five_cycle;
        lat_setup   <= cfg_setup;
        lat_hold    <= cfg_hold;
        timeout_err <= 1'b0;
      end else if (tmo) begin
        timeout_err <= 1'b1;
      end
    end
  end

  assign in_byte   = (state == ST_SETUP) || (state == ST_HOLD);
  assign nand_cle  = in_byte && cur_cmd;
  assign nand_ale  = in_byte && !cur_cmd;
  assign nand_we_n = (state != ST_SETUP);
  assign nand_io   = in_byte ? {8'h00, cur_byte} : 16'h0000;
  assign nand_ce_n = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign req_ready = (state == ST_IDLE);

  assign mark_bad = cfg_bus16 ? (mark_word != 16'hFFFF) : (mark_word[7:0] != 8'hFF);
endmodule

// File: rtl/nrs_checker.sv
`timescale 1ns/1ps
module nrs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        nand_rb,
  input logic        nand_ce_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_we_n,
  input logic [15:0] nand_io,
  input logic        busy,
  input logic        done,
  input logic        timeout_err
);
  a_r3_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  a_r3_strobe_has_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> ((nand_cle || nand_ale) && !nand_ce_n));

  a_r8_io_held_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) && !nand_ce_n) |-> ($stable(nand_io) && $stable(nand_cle)));

  a_r2_first_strobe_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) && nand_cle && (nand_io[7:0] == 8'h00)) |-> $past(nand_rb));

  a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r10_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(nand_rb) && $past(busy) && !busy));

  a_r11_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (!busy && nand_ce_n && !done));
endmodule

bind nand_read_seq nrs_checker u_chk (.*);

// File: tb/test_nand_read_seq.sv
`timescale 1ns/1ps
module test_nand_read_seq;
  localparam int TMO = 4096;

  logic        clk, rst_n, req_valid, req_ready;
  logic [13:0] req_block;
  logic [5:0]  req_page;
  logic [11:0] req_col;
  logic        req_oob, cfg_bus16, cfg_five_cycle;
  logic [3:0]  cfg_setup, cfg_hold;
  logic        nand_rb, nand_ce_n, nand_cle, nand_ale, nand_we_n;
  logic [15:0] nand_io, mark_word;
  logic        busy, done, timeout_err, mark_bad;

  nand_read_seq i_nand_read_seq (.*);

  // Stimulus {block, page, col, oob, bus16, five, setup, hold}
  localparam logic [42:0] V_IN [5] = '{
    {14'd0,    6'd0,  12'h000, 1'b0, 1'b0, 1'b0, 4'd1, 4'd1},
    {14'd3,    6'd5,  12'h123, 1'b0, 1'b0, 1'b1, 4'd2, 4'd0},
    {14'd1,    6'd2,  12'h010, 1'b1, 1'b0, 1'b0, 4'd0, 4'd2},
    {14'h3FFF, 6'd63, 12'h7FF, 1'b0, 1'b1, 1'b1, 4'd0, 4'd0},
    {14'd2,    6'd0,  12'h004, 1'b1, 1'b1, 1'b0, 4'd3, 4'd1}
  };
  // Expected strobed bytes, first byte in the top octet
  localparam logic [55:0] V_EXP [5] = '{
    56'h00_00_00_00_00_30_00,
    56'h00_23_01_C5_00_00_30,
    56'h00_10_08_42_00_30_00,
    56'h00_FF_03_FF_FF_0F_30,
    56'h00_02_04_80_00_30_00
  };

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0, fall_cyc = 0, rise_cyc = 0, rb_rise_cyc = 0, bcnt = 0;
  int cap_n = 0;
  int cap_byte [64], cap_cle [64], cap_ale [64], cap_low [64], cap_hold [64], cap_gap [64];
  bit we_prev = 1, gap = 0, force_busy = 0;

  initial clk = 0;
  always #5 clk = ~clk;

  // Monitor and device ready model, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (we_prev && !nand_we_n) begin
        if (cap_n > 0) cap_hold[cap_n % 64] = cyc - rise_cyc;
        fall_cyc = cyc;
      end
      if (!we_prev && nand_we_n) begin
        cap_byte[cap_n % 64] = int'(nand_io[7:0]);
        cap_cle[cap_n % 64]  = int'(nand_cle);
        cap_ale[cap_n % 64]  = int'(nand_ale);
        cap_low[cap_n % 64]  = cyc - fall_cyc;
        cap_gap[cap_n % 64]  = int'(gap);
        gap = 0;
        rise_cyc = cyc;
        cap_n++;
        if (nand_cle && nand_io[7:0] == 8'h30) bcnt = 10;
      end
      if (!nand_ce_n && !nand_cle && !nand_ale) gap = 1;
    end
    we_prev = nand_we_n;
    if (bcnt > 0) begin
      bcnt--;
      if (bcnt == 0) rb_rise_cyc = cyc;
    end
    nand_rb = !force_busy && (bcnt == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic issue(input logic [42:0] v);
    step();
    {req_block, req_page, req_col, req_oob, cfg_bus16, cfg_five_cycle, cfg_setup, cfg_hold} = v;
    req_valid = 1;
    step();
    req_valid = 0;
  endtask

  task automatic wait_done(output bit seen, output int at);
    seen = 0;
    at = 0;
    for (int k = 0; k < 600; k++) begin
      if (done) begin
        seen = 1;
        at = cyc;
        break;
      end
      step();
    end
  endtask

  initial begin
    bit seen;
    int at, base, n;
    rst_n = 0; req_valid = 0; req_block = '0; req_page = '0; req_col = '0;
    req_oob = 0; cfg_bus16 = 0; cfg_five_cycle = 0; cfg_setup = '0; cfg_hold = '0;
    mark_word = '0; nand_rb = 1;
    repeat (3) step();
    // R1 reset state
    chk(nand_ce_n && nand_we_n && !nand_cle && !nand_ale, "R1", "pins in reset",
        {nand_ce_n, nand_we_n, nand_cle, nand_ale}, 4'b1100);
    chk(!busy && req_ready && !done && !timeout_err, "R1", "status in reset",
        {busy, req_ready, done, timeout_err}, 4'b0100);
    rst_n = 1;
    step();
    chk(nand_ce_n && nand_we_n && !busy && req_ready, "R1", "idle after reset",
        {nand_ce_n, nand_we_n, busy, req_ready}, 4'b1101);

    // Table walk
    for (int v = 0; v < 5; v++) begin
      base = cap_n;
      n = V_IN[v][8] ? 7 : 6;
      issue(V_IN[v]);
      chk(busy && !req_ready, "R10", "busy after accept", {busy, req_ready}, 2'b10);
      wait_done(seen, at);
      chk(seen, "R10", "done seen", seen, 1);
      chk(at == rb_rise_cyc + 1, "R10", "done cycle", at, rb_rise_cyc + 1);
      chk(!busy && req_ready, "R10", "idle at done", {busy, req_ready}, 2'b01);
      chk(cap_n - base == n, "R7", "byte count", cap_n - base, n);
      for (int i = 0; i < n; i++) begin
        int idx, expb;
        bit is_c;
        idx  = (base + i) % 64;
        expb = int'(V_EXP[v][55 - 8*i -: 8]);
        is_c = (i == 0) || (i == n - 1);
        if (i == 0 || i == n - 1)
          chk(cap_byte[idx] == expb, "R3", "opcode", cap_byte[idx], expb);
        else if (i < 3)
          chk(cap_byte[idx] == expb, "R5 R6", "column byte", cap_byte[idx], expb);
        else
          chk(cap_byte[idx] == expb, "R4 R7", "row byte", cap_byte[idx], expb);
        chk(cap_cle[idx] == int'(is_c) && cap_ale[idx] == int'(!is_c), "R3", "latch kind",
            {cap_cle[idx][0], cap_ale[idx][0]}, {is_c, !is_c});
        chk(cap_low[idx] == int'(V_IN[v][7:4]) + 1, "R8", "strobe low width",
            cap_low[idx], int'(V_IN[v][7:4]) + 1);
        if (i > 0 && i < n - 1)
          chk(cap_hold[idx] == int'(V_IN[v][3:0]) + 1, "R8", "strobe high width",
              cap_hold[idx], int'(V_IN[v][3:0]) + 1);
        if (i == n - 1) begin
          chk(cap_hold[idx] == int'(V_IN[v][3:0]) + 2, "R9", "gap before confirm",
              cap_hold[idx], int'(V_IN[v][3:0]) + 2);
          chk(cap_gap[idx] == 1, "R9", "latches idle in gap", cap_gap[idx], 1);
        end
      end
    end

    // R2: hold busy at request, no strobe until ready
    force_busy = 1;
    base = cap_n;
    issue(V_IN[0]);
    repeat (30) step();
    chk(cap_n == base, "R2", "no strobe while busy", cap_n - base, 0);
    chk(!nand_ce_n && busy, "R2", "enabled while waiting", {nand_ce_n, busy}, 2'b01);
    force_busy = 0;
    wait_done(seen, at);
    chk(seen && cap_n - base == 6, "R2", "sequence after ready", cap_n - base, 6);
    chk(cap_cle[base % 64] == 1 && cap_byte[base % 64] == 0, "R2", "first byte read opcode",
        cap_byte[base % 64], 0);

    // R11: ready never comes
    force_busy = 1;
    base = cap_n;
    issue(V_IN[1]);
    seen = 0;
    for (int k = 0; k < TMO + 100; k++) begin
      if (timeout_err) begin seen = 1; break; end
      step();
    end
    chk(seen, "R11", "timeout flag", seen, 1);
    chk(!busy && nand_ce_n && req_ready, "R11", "idle after timeout",
        {busy, nand_ce_n, req_ready}, 3'b011);
    chk(cap_n == base, "R11", "no strobes on timeout", cap_n - base, 0);
    repeat (5) step();
    chk(timeout_err, "R11", "flag holds", timeout_err, 1);
    force_busy = 0;
    issue(V_IN[0]);
    chk(!timeout_err, "R11", "flag cleared on accept", timeout_err, 0);
    wait_done(seen, at);
    chk(seen, "R11", "recovers after timeout", seen, 1);

    // R12 marker compare
    cfg_bus16 = 0; mark_word = 16'h00FF; #1;
    chk(!mark_bad, "R12", "8-bit all ones", mark_bad, 0);
    mark_word = 16'hFFFE; #1;
    chk(mark_bad, "R12", "8-bit bad", mark_bad, 1);
    cfg_bus16 = 1; mark_word = 16'h00FF; #1;
    chk(mark_bad, "R12", "16-bit upper zero", mark_bad, 1);
    mark_word = 16'hFFFF; #1;
    chk(!mark_bad, "R12", "16-bit all ones", mark_bad, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule